// File: doc/BRIEF.md
# Low-Power Sensor Coprocessor Core

A small multi-cycle processor core that keeps working while its host sleeps. It runs fixed-width 32-bit instructions out of an internal single-port RAM of 32-bit words. The same RAM holds both the program and its data. The core has four 16-bit general registers, R0 to R3. It executes:

- register-register and register-immediate ALU operations;
- word-addressed loads and stores relative to a base register;
- two compare-and-branch forms that always test R0 against a 16-bit immediate;
- a programmable delay;
- a halt.

While the core is halted, the host fills and reads the RAM through a simple word port. It then pulses a start strobe together with a start address, and waits for the halted flag to return. A load moves the low half of a memory word into a register. A store writes a register into a full word, zero-extended.

Top module: `sense_core`

## Requirements
- R1: After reset, halted is 1 and all four registers read as zero. While halted, a host write with hostWe=1 stores hostWdata at hostAddr. hostRdata shows the word at hostAddr one clock edge after that address is presented.
- R2: A start strobe seen while halted clears halted and begins fetching at startAddr. A start strobe seen while running has no effect on the program's result or its cycle count.
- R3: Instruction fields are: opcode [31:28], sub-operation [27:25], Rd [24:23], Rs1 [22:21], Rs2 [20:19], immediate [15:0]. Opcode 0 is the register form, Rd <= Rs1 op Rs2. Sub-operation codes are 0 add, 1 subtract, 2 AND, 3 OR, 4 move (copies the second operand), 5 left shift, 6 right shift.
- R4: Opcode 1 is the immediate form, Rd <= Rs1 op imm, using the same sub-operation codes as R3.
- R5: Add and subtract wrap modulo 2^16. A shift amount of 16 or more gives zero. The right shift is logical.
- R6: Opcode 2 loads. Rd <= bits [15:0] of the word at address (Rs1 + imm) mod 2^ADDR_W, where imm is taken as a signed 16-bit offset.
- R7: Opcode 3 stores. The word at (Rs1 + imm) mod 2^ADDR_W becomes {16'h0, Rd}.
- R8: Opcode 4 jumps to the absolute word address in bits [26:16] when R0 < imm, unsigned. Opcode 7 jumps there when R0 >= imm. Otherwise the next word is fetched.
- R9: Opcode 5 idles for imm clock cycles (zero meaning none) before the next fetch.
- R10: Opcode 6 halts. So do opcodes 8 to 15 and ALU sub-operation 7. No later instruction is executed.
- R11: Timing, counted from the edge that accepts the start strobe:
  - ALU and branch instructions take 2 cycles each;
  - loads and stores take 3;
  - a delay takes 2 plus imm;
  - a halt takes 2, after which halted reads 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startStrobe | input | 1 | Start request, taken only while halted |
| startAddr | input | ADDR_W | Word address of the first instruction |
| halted | output | 1 | Core idle, host owns the RAM |
| hostWe | input | 1 | Host write enable (used while halted) |
| hostAddr | input | ADDR_W | Host word address |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Registered RAM read data |

## Verification
Assertions check on every cycle that:
- fetch is always followed by execute, and the memory cycle lasts exactly one cycle;
- a delay never waits on a zero count;
- a halt opcode leads to the halted state, and an idle core stays idle without a strobe;
- a taken branch lands on its encoded target;
- a load writes back the fetched low half.

Only the bench scenarios can show:
- the arithmetic results and wrap and shift limits;
- signed offsets and address wrap;
- zero extension of stores;
- that a start strobe issued while running changes nothing;
- the exact total cycle count of each program.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int DATA_W   = 16;
  localparam int WORD_W   = 32;
  localparam int NUM_REGS = 4;
  localparam int RIDX_W   = $clog2(NUM_REGS);
  localparam int TGT_W    = 11;

  typedef enum logic [3:0] {
    OP_ALUR = 4'd0, OP_ALUI = 4'd1, OP_LOAD = 4'd2, OP_STORE = 4'd3,
    OP_BLT  = 4'd4, OP_DELAY = 4'd5, OP_HALT = 4'd6, OP_BGE = 4'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_MOV, ALU_LSH, ALU_RSH, ALU_BAD
  } aluop_e;

  typedef enum logic [2:0] {ST_IDLE, ST_FETCH, ST_EXEC, ST_MEM, ST_WAIT} state_e;

  typedef enum logic [1:0] {MA_HOST, MA_PC, MA_EFF} memsel_e;

  typedef struct packed {
    logic     pcStart;
    logic     pcInc;
    logic     pcJump;
    logic     regWrAlu;
    logic     regWrLoad;
    logic     memWe;
    logic     latchRd;
    memsel_e  memSel;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] aluCalc(aluop_e op, logic [DATA_W-1:0] a,
                                                logic [DATA_W-1:0] b);
    logic tooFar;
    tooFar = (b >= DATA_W[DATA_W-1:0]);
    case (op)
      ALU_ADD: aluCalc = a + b;
      ALU_SUB: aluCalc = a - b;
      ALU_AND: aluCalc = a & b;
      ALU_OR:  aluCalc = a | b;
      ALU_MOV: aluCalc = b;
      ALU_LSH: aluCalc = tooFar ? '0 : a << b[3:0];
      ALU_RSH: aluCalc = tooFar ? '0 : a >> b[3:0];
      default: aluCalc = '0;
    endcase
  endfunction
endpackage

// File: rtl/sc_ram.sv
module sc_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [3:0]        instrOp,
  input  logic [2:0]        instrSub,
  input  logic [DATA_W-1:0] instrImm,
  input  logic              brTaken,
  output ctrl_t             ctl,
  output logic              halted
);
  state_e            state, nextState;
  logic [DATA_W-1:0] waitQ;
  logic              isLoadQ;

  always_comb begin
    ctl        = '0;
    ctl.memSel = MA_PC;
    nextState  = state;
    case (state)
      ST_IDLE: begin
        ctl.memSel = MA_HOST;
        if (startStrobe) begin
          ctl.pcStart = 1'b1;
          nextState   = ST_FETCH;
        end
      end
      ST_FETCH: nextState = ST_EXEC;
      ST_EXEC: begin
        nextState = ST_FETCH;
        case (instrOp)
          OP_ALUR, OP_ALUI: begin
            if (instrSub == ALU_BAD) nextState = ST_IDLE;
            else begin
              ctl.regWrAlu = 1'b1;
              ctl.pcInc    = 1'b1;
            end
          end
          OP_LOAD: begin
            ctl.memSel  = MA_EFF;
            ctl.latchRd = 1'b1;
            ctl.pcInc   = 1'b1;
            nextState   = ST_MEM;
          end
          OP_STORE: begin
            ctl.memSel = MA_EFF;
            ctl.memWe  = 1'b1;
            ctl.pcInc  = 1'b1;
            nextState  = ST_MEM;
          end
          OP_BLT, OP_BGE: begin
            ctl.pcJump = brTaken;
            ctl.pcInc  = !brTaken;
          end
          OP_DELAY: begin
            ctl.pcInc = 1'b1;
            if (instrImm != '0) nextState = ST_WAIT;
          end
          default: nextState = ST_IDLE;
        endcase
      end
      ST_MEM: begin
        ctl.regWrLoad = isLoadQ;
        nextState     = ST_FETCH;
      end
      ST_WAIT: if (waitQ == 16'd1) nextState = ST_FETCH;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      waitQ   <= '0;
      isLoadQ <= 1'b0;
    end else begin
      state <= nextState;
      if (state == ST_EXEC) begin
        isLoadQ <= (instrOp == OP_LOAD);
        waitQ   <= instrImm;
      end else if (state == ST_WAIT) begin
        waitQ <= waitQ - 16'd1;
      end
    end
  end

  assign halted = (state == ST_IDLE);

  assert_fetch_then_exec_R11: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_FETCH |=> state == ST_EXEC);
  assert_mem_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_MEM |=> state == ST_FETCH);
  assert_wait_nonzero_R9: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_WAIT |-> waitQ != '0);
  assert_halt_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && instrOp == OP_HALT) |=> halted);
  assert_idle_stays_R1: assert property (@(posedge clk) disable iff (!rstN)
    (halted && !startStrobe) |=> halted);
  assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!halted && state != ST_EXEC && startStrobe) |=> !halted);
endmodule

// File: rtl/sc_dpath.sv
module sc_dpath
  import sc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [WORD_W-1:0] hostWdata,
  output logic [WORD_W-1:0] ramRdata,
  output logic              brTaken
);
  logic [ADDR_W-1:0] pc, effAddr, ramAddr;
  logic [RIDX_W-1:0] rd, rs1, rs2, ldRdQ;
  logic [DATA_W-1:0] imm, opA, opB, aluRes;
  logic [DATA_W-1:0] regVal [NUM_REGS];
  logic [WORD_W-1:0] ramWdata;
  logic              ramWe;
  logic [3:0]        opcode;

  assign opcode  = ramRdata[31:28];
  assign rd      = ramRdata[24:23];
  assign rs1     = ramRdata[22:21];
  assign rs2     = ramRdata[20:19];
  assign imm     = ramRdata[15:0];
  assign opA     = regVal[rs1];
  assign opB     = (opcode == OP_ALUI) ? imm : regVal[rs2];
  assign aluRes  = aluCalc(aluop_e'(ramRdata[27:25]), opA, opB);
  assign effAddr = ADDR_W'(opA + imm);
  assign brTaken = (opcode == OP_BLT) ? (regVal[0] < imm) : (regVal[0] >= imm);

  for (genvar g = 0; g < NUM_REGS; g++) begin : gRegs
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (ctl.regWrAlu && rd == RIDX_W'(g)) q <= aluRes;
      else if (ctl.regWrLoad && ldRdQ == RIDX_W'(g)) q <= ramRdata[DATA_W-1:0];
    end
    assign regVal[g] = q;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pc    <= '0;
      ldRdQ <= '0;
    end else begin
      if (ctl.pcStart)     pc <= startAddr;
      else if (ctl.pcJump) pc <= ramRdata[16 +: ADDR_W];
      else if (ctl.pcInc)  pc <= pc + 1'b1;
      if (ctl.latchRd) ldRdQ <= rd;
    end
  end

  always_comb begin
    case (ctl.memSel)
      MA_HOST: begin ramAddr = hostAddr; ramWe = hostWe;    ramWdata = hostWdata; end
      MA_EFF:  begin ramAddr = effAddr;  ramWe = ctl.memWe; ramWdata = {16'h0, regVal[rd]}; end
      default: begin ramAddr = pc;       ramWe = 1'b0;      ramWdata = {16'h0, regVal[rd]}; end
    endcase
  end

  sc_ram #(.AW(ADDR_W), .DW(WORD_W)) uRam (
    .clk(clk), .we(ramWe), .addr(ramAddr), .wdata(ramWdata), .rdata(ramRdata)
  );

  assert_branch_target_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pcJump |=> pc == $past(ramRdata[16 +: ADDR_W]));
  assert_load_writeback_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.regWrLoad |=> regVal[$past(ldRdQ)] == $past(ramRdata[DATA_W-1:0]));
endmodule

// File: rtl/sense_core.sv
module sense_core
  import sc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrobe,
  input  logic [ADDR_W-1:0] startAddr,
  output logic              halted,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [31:0]       hostWdata,
  output logic [31:0]       hostRdata
);
  ctrl_t       ctl;
  logic [31:0] instr;
  logic        brTaken;

  sc_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .startStrobe(startStrobe),
    .instrOp(instr[31:28]), .instrSub(instr[27:25]), .instrImm(instr[15:0]),
    .brTaken(brTaken), .ctl(ctl), .halted(halted)
  );

  sc_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startAddr(startAddr),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .ramRdata(instr), .brTaken(brTaken)
  );

  assign hostRdata = instr;
endmodule

// File: tb/tb_sense_core.sv
module tb_sense_core;
  logic        clk = 0, rstN = 0, startStrobe = 0, hostWe = 0;
  logic [7:0]  startAddr = 0, hostAddr = 0;
  logic [31:0] hostWdata = 0, hostRdata;
  logic        halted;
  int checks = 0, failures = 0;

  sense_core #(.ADDR_W(8)) dut (.*);

  always #5 clk = ~clk;

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] eR(int sub, int rd, int rs1, int rs2);
    return {4'd0, 3'(sub), 2'(rd), 2'(rs1), 2'(rs2), 19'd0};
  endfunction
  function automatic logic [31:0] eI(int sub, int rd, int rs, logic [15:0] imm);
    return {4'd1, 3'(sub), 2'(rd), 2'(rs), 5'd0, imm};
  endfunction
  function automatic logic [31:0] eLd(int rd, int rs, logic [15:0] off);
    return {4'd2, 3'd0, 2'(rd), 2'(rs), 5'd0, off};
  endfunction
  function automatic logic [31:0] eSt(int rd, int rs, logic [15:0] off);
    return {4'd3, 3'd0, 2'(rd), 2'(rs), 5'd0, off};
  endfunction
  function automatic logic [31:0] eBr(logic [3:0] op, int tgt, logic [15:0] imm);
    return {op, 1'b0, 11'(tgt), imm};
  endfunction
  function automatic logic [31:0] eDly(logic [15:0] n);
    return {4'd5, 12'd0, n};
  endfunction
  localparam logic [31:0] HALT = 32'h6000_0000;

  function automatic logic [15:0] refAlu(int sub, logic [15:0] a, logic [15:0] b);
    logic [31:0] w;
    case (sub)
      0: w = 32'(a) + 32'(b);
      1: w = 32'(a) + 32'(~b) + 1;
      2: w = 32'(a & b);
      3: w = 32'(a | b);
      4: w = 32'(b);
      5: w = (b > 15) ? 0 : (32'(a) << b);
      default: w = (b > 15) ? 0 : (32'(a) >> b);
    endcase
    return w[15:0];
  endfunction

  task automatic hostWrite(input logic [7:0] a, input logic [31:0] d);
    hostAddr = a; hostWdata = d; hostWe = 1;
    @(posedge clk); #1 hostWe = 0;
  endtask

  task automatic hostRead(input logic [7:0] a, output logic [31:0] d);
    hostAddr = a; hostWe = 0;
    @(posedge clk); #1 d = hostRdata;
  endtask

  task automatic runProg(input logic [7:0] addr, input int midStart, output int cyc);
    @(negedge clk); startAddr = addr; startStrobe = 1;
    @(posedge clk); #1 startStrobe = 0;
    cyc = 0;
    while (1) begin
      @(posedge clk); #1; cyc++;
      if (midStart != 0 && cyc == midStart) begin startStrobe = 1; startAddr = 8'd0; end
      else startStrobe = 0;
      if (halted || cyc > 5000) break;
    end
    startStrobe = 0;
  endtask

  task automatic loadProg(input logic [7:0] base, input logic [31:0] p[]);
    foreach (p[i]) hostWrite(base + 8'(i), p[i]);
  endtask

  initial begin
    logic [31:0] rd;
    int cyc;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(posedge clk); #1;

    // R1: reset state and host port
    check("R1 halted after reset", halted, 1);
    hostWrite(8'd245, 32'h1111_1111);
    hostRead(8'd245, rd);
    check("R1 host write/read", rd, 32'h1111_1111);
    for (int k = 0; k < 4; k++) hostWrite(8'(245 + k), 32'hCAFE_0000 + k);
    loadProg(8'd80, '{eSt(0, 0, 16'd245), eSt(1, 1, 16'd246), eSt(2, 2, 16'd247),
                     eSt(3, 3, 16'd248), HALT});
    runProg(8'd80, 0, cyc);
    for (int k = 0; k < 4; k++) begin
      hostRead(8'(245 + k), rd);
      check($sformatf("R1 reg R%0d zero after reset (R7 zext)", k), rd, 0);
    end
    check("R11 four stores plus halt cycles", cyc, 14);

    // R8 loop with R4 immediates, BL taken and not taken
    loadProg(8'd0, '{eI(4, 0, 0, 0), eI(4, 1, 0, 0), eI(4, 2, 0, 200),
                    eI(0, 1, 1, 3), eI(0, 0, 0, 1), eBr(4'd4, 3, 16'd5),
                    eSt(1, 2, 0), eSt(0, 2, 1), HALT});
    runProg(8'd0, 0, cyc);
    check("R11 loop cycles", cyc, 44);
    hostRead(8'd200, rd); check("R8 loop sum R1", rd, 15);
    hostRead(8'd201, rd); check("R8 loop count R0", rd, 5);

    // R8 BGE equal taken, greater not taken; R2 start address
    loadProg(8'd20, '{eI(4, 2, 0, 210), eI(4, 0, 0, 10), eBr(4'd7, 24, 16'd10),
                     eI(4, 3, 0, 16'h1111), eBr(4'd7, 26, 16'd11), eI(4, 3, 0, 16'h2222),
                     eSt(3, 2, 0), HALT});
    hostWrite(8'd0, HALT);
    @(negedge clk); startAddr = 8'd20; startStrobe = 1;
    @(posedge clk); #1 startStrobe = 0;
    check("R2 halted clears on start", halted, 0);
    cyc = 0;
    while (!halted && cyc < 5000) begin @(posedge clk); #1; cyc++; end
    check("R11 branch program cycles", cyc, 15);
    hostRead(8'd210, rd); check("R8 BGE paths", rd, 32'h2222);

    // R6 R7 load/store, negative offset, zero extension, address wrap
    hostWrite(8'd230, 32'hABCD_1234);
    hostWrite(8'd231, 32'hDEAD_BEEF);
    hostWrite(8'd232, 32'hFFFF_FFFF);
    loadProg(8'd40, '{eI(4, 1, 0, 232), eLd(2, 1, 16'hFFFE), eSt(2, 1, 16'hFFFF),
                     eI(4, 3, 0, 16'hFFF0), eSt(2, 3, 16'h00F8), HALT});
    runProg(8'd40, 0, cyc);
    check("R11 load/store cycles", cyc, 15);
    hostRead(8'd231, rd); check("R6 R7 load low half, store zero-extended", rd, 32'h0000_1234);
    hostRead(8'd232, rd); check("R7 wrapped address store", rd, 32'h0000_1234);
    hostRead(8'd230, rd); check("R6 load source untouched", rd, 32'hABCD_1234);

    // R9 delay, R2 start ignored while running
    loadProg(8'd50, '{eI(4, 0, 0, 1), eDly(16'd7), HALT, eDly(16'd0), HALT});
    runProg(8'd50, 0, cyc);
    check("R9 delay 7 cycles", cyc, 13);
    runProg(8'd53, 0, cyc);
    check("R9 delay zero cycles", cyc, 4);
    hostWrite(8'd0, eI(4, 0, 0, 16'h7777));
    hostWrite(8'd1, HALT);
    runProg(8'd50, 4, cyc);
    check("R2 mid-run start ignored cycles", cyc, 13);
    loadProg(8'd54, '{eI(4, 2, 0, 236), eSt(0, 2, 0), HALT});
    runProg(8'd54, 0, cyc);
    hostRead(8'd236, rd); check("R2 mid-run start left R0", rd, 1);

    // R10 unknown opcode and bad sub-operation halt
    hostWrite(8'd240, 32'h5A5A_5A5A);
    loadProg(8'd60, '{eI(4, 1, 0, 240), 32'hF000_0000, eSt(1, 1, 0), HALT});
    runProg(8'd60, 0, cyc);
    check("R10 unknown opcode halts", cyc, 4);
    hostRead(8'd240, rd); check("R10 no instruction after unknown opcode", rd, 32'h5A5A_5A5A);
    loadProg(8'd70, '{eI(7, 1, 1, 0), eSt(1, 1, 0), HALT});
    runProg(8'd70, 0, cyc);
    check("R10 bad sub-operation halts", cyc, 2);
    hostRead(8'd240, rd); check("R10 store after bad sub skipped", rd, 32'h5A5A_5A5A);

    // R3 R4 R5 random ALU programs against the bench model
    for (int it = 0; it < 30; it++) begin
      logic [15:0] m[4];
      logic [31:0] prog[17];
      for (int k = 0; k < 4; k++) begin
        m[k] = 16'($urandom);
        prog[k] = eI(4, k, 0, m[k]);
      end
      for (int j = 0; j < 8; j++) begin
        int sub = $urandom_range(0, 6);
        int d = $urandom_range(0, 3), s1 = $urandom_range(0, 3), s2 = $urandom_range(0, 3);
        logic [15:0] imm = (sub >= 5) ? 16'($urandom_range(0, 20)) : 16'($urandom);
        if ($urandom_range(0, 1) == 1) begin
          prog[4 + j] = eI(sub, d, s1, imm);
          m[d] = refAlu(sub, m[s1], imm);
        end else begin
          prog[4 + j] = eR(sub, d, s1, s2);
          m[d] = refAlu(sub, m[s1], m[s2]);
        end
      end
      for (int k = 0; k < 4; k++) prog[12 + k] = eSt(k, k, 16'(250 + k) - m[k]);
      prog[16] = HALT;
      for (int k = 0; k < 17; k++) hostWrite(8'(100 + k), prog[k]);
      runProg(8'd100, 0, cyc);
      check("R11 random program cycles", cyc, 38);
      for (int k = 0; k < 4; k++) begin
        hostRead(8'(250 + k), rd);
        check($sformatf("R3 R4 R5 random iter %0d R%0d", it, k), rd, {16'h0, m[k]});
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule